// File: doc/BRIEF.md
# ADC conversion sequence controller

This block is the digital sequencer that sits in front of an on-chip analog-to-digital converter core. Software sets it up through a byte-wide register port: power and wait-halt control, sequence length, result resolution with sample time and clock prescaler, and a mode/channel register. A write to the mode/channel register launches a sequence of four or eight conversions. For each conversion the sequencer waits out the programmed sample time, presents a 3-bit channel select with a one-cycle start pulse to the converter core, and waits for the core's done handshake. It then stores the sample in the next numbered result slot.

Each result slot has its own completion flag, and a separate flag marks the end of a whole sequence. In single-shot mode the sequencer goes idle after the last conversion. In scan mode it wraps back to slot 0 and keeps converting. The channel either stays fixed or steps upward from a base inside a group of four or eight channels. A stop request aborts all activity. Power-down, or a wait request while wait-halt is enabled, freezes the sequencer in place. The analog front end is modelled by the `conv_sample` / `conv_done` handshake.

Top module: `adc_seq_ctrl`

Register map (byte writes, addresses on `wr_addr` / `rd_addr`):

- Address 0: bit0 is power-up, bit1 is wait-halt enable.
- Address 1: bit0 selects the length, 0 for four conversions and 1 for eight.
- Address 2: bit0 selects 8-bit results. Bits 2:1 are the sample code, giving 2, 4, 8 or 16 converter clocks for codes 0 to 3. Bits 7:3 are the prescaler P, so one converter clock lasts P+1 system clocks.
- Address 3: bit0 selects scan mode, bit1 selects channel stepping, bits 4:2 are the base channel. Any write to this address starts a sequence.
- Address 4 (read only): bit8 is the sequence flag, bits 7:0 are the completion flags of slots 7..0.
- Addresses 8 to 15 (read only): result slots 0 to 7.
- All other addresses read as zero.

Reads return their data in `rd_data` in the cycle after `rd_en`.

## Requirements
- R1: After reset, `conv_start` is low, the status word at address 4 reads 0 and the power register at address 0 reads 0.
- R2: After a write to address 3, with prescaler P and sample code c, the first `conv_start` pulse rises exactly (P+1)·(2<<c) clock cycles after the write edge, and every `conv_start` pulse lasts one cycle.
- R3: In single-shot mode (address 3 bit0 = 0) a sequence performs exactly 4 conversions (address 1 bit0 = 0) or 8 conversions (bit0 = 1), sets status bit8 after the last one, and issues no further `conv_start`.
- R4: In scan mode (address 3 bit0 = 1) the sequence flag is set after the last conversion, and the next conversion writes result slot 0 again.
- R5: Storing a result into slot k sets status bit k. A read of address 8+k clears bit k only.
- R6: With address 3 bit1 = 0, every conversion of the sequence drives `conv_chan` equal to the base channel in bits 4:2.
- R7: With address 3 bit1 = 1, conversion k drives channel base+k modulo 8 for length 8. For length 4 it drives {base[2], (base[1:0]+k) mod 4}.
- R8: With address 2 bit0 = 0 a slot holds the full 10-bit sample. With bit0 = 1 it holds the sample shifted right by 2.
- R9: A `stop_in` pulse aborts the sequence. No further `conv_start` follows, and a `conv_done` that arrives afterwards stores nothing.
- R10: While `wait_in` is high and address 0 bit1 = 1, the sequencer issues no `conv_start`, and it resumes when `wait_in` falls. With bit1 = 0, `wait_in` has no effect.
- R11: While address 0 bit0 = 0, no conversion is issued, the configuration and status registers stay readable, and setting the bit resumes the pending sequence.
- R12: A write to address 3 during a running sequence clears all completion flags and the sequence flag at once and restarts at slot 0, where the first new conversion is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Read data, one cycle after rd_en |
| stop_in | input | 1 | Stop request, aborts activity |
| wait_in | input | 1 | Wait request, halts if enabled |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_chan | output | 3 | Channel mux select for the conversion |
| conv_done | input | 1 | Converter core result-valid strobe |
| conv_sample | input | 10 | Converter core sample value |

## Verification
The first start pulse is due (P+1)·(2<<c) cycles after the mode-register write edge. The bench sweeps all sixteen prescaler and sample-code pairs of a small range and counts clock edges from the write up to the negative edge where `conv_start` is seen high. A stored result and its flag change at the clock edge that samples `conv_done`. Read data appears one edge after `rd_en`, so each read is launched on a falling edge and checked on the next falling edge. Results are compared against samples logged by the bench's core model. Absence checks for stop, wait, power-down and single-shot end watch `conv_start` over windows hundreds of cycles longer than the longest programmed sample time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CHW = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV
  } seq_state_t;

  typedef struct packed {
    logic           pwr;
    logic           halt_en;
    logic           len8;
    logic           res8;
    logic [1:0]     samp_code;
    logic [4:0]     presc;
    logic           scan;
    logic           multi;
    logic [CHW-1:0] base;
  } seq_cfg_t;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  output seq_cfg_t         cfg,
  output logic [3:0][7:0]  cfg_bytes,
  output logic             mode_wr
);

  localparam int NCFG = 4;

  generate
    for (genvar i = 0; i < NCFG; i++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) begin
          cfg_bytes[i] <= '0;
        end else if (wr_en && wr_addr == AW'(i)) begin
          cfg_bytes[i] <= wr_data;
        end
      end
    end
  endgenerate

  assign mode_wr = wr_en && (wr_addr == AW'(3));

  always_comb begin
    cfg.pwr       = cfg_bytes[0][0];
    cfg.halt_en   = cfg_bytes[0][1];
    cfg.len8      = cfg_bytes[1][0];
    cfg.res8      = cfg_bytes[2][0];
    cfg.samp_code = cfg_bytes[2][2:1];
    cfg.presc     = cfg_bytes[2][7:3];
    cfg.scan      = cfg_bytes[3][0];
    cfg.multi     = cfg_bytes[3][1];
    cfg.base      = cfg_bytes[3][4:2];
  end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int PW = 5,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          en,
  input  logic [PW-1:0] presc,
  input  logic [1:0]    samp_code,
  output logic          done
);

  logic [PW-1:0] pcnt;
  logic [SW-1:0] scnt;
  logic [SW-1:0] s_last;
  logic          tick;

  assign s_last = (SW'(2) << samp_code) - SW'(1);
  assign tick   = en && (pcnt == presc);
  assign done   = tick && (scnt == s_last);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pcnt <= '0;
      scnt <= '0;
    end else if (en) begin
      if (tick) begin
        pcnt <= '0;
        scnt <= done ? '0 : scnt + SW'(1);
      end else begin
        pcnt <= pcnt + PW'(1);
      end
    end
  end

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int NRES = 8,
  parameter int DW   = 10,
  localparam int IW  = $clog2(NRES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_en,
  input  logic [IW-1:0]   st_idx,
  input  logic [DW-1:0]   st_data,
  input  logic            clr_all,
  input  logic            rd_en,
  input  logic [IW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_q,
  output logic [NRES-1:0] ccf
);

  logic [DW-1:0] mem [NRES];

  always_ff @(posedge clk) begin
    if (st_en) mem[st_idx] <= st_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

  generate
    for (genvar i = 0; i < NRES; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)                                ccf[i] <= 1'b0;
        else if (clr_all)                       ccf[i] <= 1'b0;
        else if (st_en && st_idx == IW'(i))     ccf[i] <= 1'b1;
        else if (rd_en && rd_idx == IW'(i))     ccf[i] <= 1'b0;
      end

      // R5: a read of slot i clears its flag when no store targets it
      a_r5_read_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_idx == IW'(i) && !(st_en && st_idx == IW'(i))) |=> !ccf[i]);
    end
  endgenerate

  // R5: a store raises the flag of the slot it wrote
  a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
    (st_en && !clr_all) |=> ccf[$past(st_idx)]);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DW  = 10,
  parameter int AW  = 4,
  parameter int RDW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [RDW-1:0] rd_data,
  input  logic           stop_in,
  input  logic           wait_in,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_sample
);

  localparam int NRES = 1 << CHW;
  localparam int IW   = CHW;

  seq_cfg_t        cfg;
  logic [3:0][7:0] cfg_bytes;
  logic            mode_wr;
  seq_state_t      state;
  logic [IW-1:0]   idx;
  logic [IW-1:0]   last_idx;
  logic            seq_flag;
  logic            run;
  logic            tmr_done;
  logic            accept;
  logic [CHW-1:0]  chan_calc;
  logic [DW-1:0]   st_data;
  logic [NRES-1:0] ccf;
  logic [DW-1:0]   res_q;
  logic            rd_sel_res;
  logic [RDW-1:0]  rd_other_q;

  adc_seq_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .cfg_bytes(cfg_bytes), .mode_wr(mode_wr)
  );

  assign run = cfg.pwr && !(wait_in && cfg.halt_en);

  adc_seq_timer #(.PW(5), .SW(5)) u_timer (
    .clk(clk), .rst(rst),
    .clear(stop_in || mode_wr || state != ST_SAMPLE),
    .en(run), .presc(cfg.presc), .samp_code(cfg.samp_code), .done(tmr_done)
  );

  assign last_idx = cfg.len8 ? IW'(NRES - 1) : IW'(NRES / 2 - 1);
  assign accept   = (state == ST_CONV) && run && conv_done && !stop_in && !mode_wr;
  assign st_data  = cfg.res8 ? DW'(conv_sample[DW-1:DW-8]) : conv_sample;

  always_comb begin
    if (!cfg.multi)    chan_calc = cfg.base;
    else if (cfg.len8) chan_calc = cfg.base + idx;
    else               chan_calc = {cfg.base[CHW-1], cfg.base[CHW-2:0] + idx[CHW-2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      seq_flag   <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= 1'b0;
      if (stop_in) begin
        state <= ST_IDLE;
      end else if (mode_wr) begin
        state    <= ST_SAMPLE;
        idx      <= '0;
        seq_flag <= 1'b0;
      end else if (run) begin
        case (state)
          ST_SAMPLE: if (tmr_done) begin
            state      <= ST_CONV;
            conv_start <= 1'b1;
            conv_chan  <= chan_calc;
          end
          ST_CONV: if (conv_done) begin
            if (idx == last_idx) begin
              seq_flag <= 1'b1;
              idx      <= '0;
              state    <= cfg.scan ? ST_SAMPLE : ST_IDLE;
            end else begin
              idx   <= idx + IW'(1);
              state <= ST_SAMPLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  adc_seq_results #(.NRES(NRES), .DW(DW)) u_res (
    .clk(clk), .rst(rst), .st_en(accept), .st_idx(idx), .st_data(st_data),
    .clr_all(mode_wr && !stop_in), .rd_en(rd_en && rd_addr[AW-1]),
    .rd_idx(rd_addr[IW-1:0]), .rd_q(res_q), .ccf(ccf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_res <= 1'b0;
      rd_other_q <= '0;
    end else if (rd_en) begin
      rd_sel_res <= rd_addr[AW-1];
      case (rd_addr)
        AW'(0), AW'(1), AW'(2), AW'(3): rd_other_q <= RDW'(cfg_bytes[rd_addr[1:0]]);
        AW'(4):                         rd_other_q <= RDW'({seq_flag, ccf});
        default:                        rd_other_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_sel_res ? RDW'(res_q) : rd_other_q;

  // R2: the start strobe never lasts more than one cycle
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R9: a stop request leaves the sequencer idle with no start issued
  a_r9_stop_abort: assert property (@(posedge clk) disable iff (rst)
    stop_in |=> (state == ST_IDLE && !conv_start));

  // R12: a mode write clears every flag and restarts at slot 0
  a_r12_restart: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !stop_in) |=> (ccf == '0 && !seq_flag && idx == '0 && state == ST_SAMPLE));

  // R10, R11: a halted sequencer keeps its position and issues no start
  a_r11_halt_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !stop_in && !mode_wr) |=> ($stable(state) && $stable(idx) && !conv_start));

  // R3: the sequence flag rises only after the final slot of the sequence
  a_r3_seq_end: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_flag) |-> ($past(idx) == $past(last_idx)));

  // R6: fixed-channel mode always presents the base channel
  a_r6_single_chan: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !cfg.multi) |-> (conv_chan == cfg.base));

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en, stop_in, wait_in, conv_done;
  logic [3:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data;
  logic [15:0] rd_data;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic [9:0]  conv_sample;

  int checks = 0;
  int errors = 0;
  int log_n  = 0;
  logic core_en = 1'b0;
  logic [2:0] log_chan [256];
  logic [9:0] log_samp [256];

  always #10 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .stop_in(stop_in),
    .wait_in(wait_in), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_sample(conv_sample)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic stop_pulse();
    @(negedge clk); stop_in = 1'b1;
    @(negedge clk); stop_in = 1'b0;
  endtask

  task automatic wait_seq();
    logic [15:0] d;
    for (int i = 0; i < 4000; i++) begin
      rd(4'd4, d);
      if (d[8]) return;
    end
  endtask

  task automatic quiet(input int cyc, input int s, input string req);
    repeat (cyc) @(negedge clk);
    chk(log_n == s, req, log_n - s, 0);
  endtask

  function automatic logic [9:0] samp_of(input logic [2:0] ch, input int n);
    return 10'((int'(ch) * 97 + n * 13 + 5) % 1024);
  endfunction

  // converter core model: answers each start pulse three edges later
  initial begin
    conv_done = 1'b0; conv_sample = '0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        logic [9:0] smp;
        smp = samp_of(conv_chan, log_n);
        log_chan[log_n & 255] = conv_chan;
        log_samp[log_n & 255] = smp;
        log_n++;
        if (core_en) begin
          repeat (2) @(negedge clk);
          conv_done = 1'b1; conv_sample = smp;
          @(negedge clk);
          conv_done = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int s, n;
    rst = 1'b1; wr_en = 0; rd_en = 0; stop_in = 0; wait_in = 0;
    wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(conv_start == 1'b0, "R1 start", int'(conv_start), 0);
    rd(4'd4, d); chk(d == 16'h0, "R1 status", d, 0);
    rd(4'd0, d); chk(d == 16'h0, "R1 power", d, 0);

    // R2 first-start latency sweep
    wr(4'd0, 8'h01); wr(4'd1, 8'h00);
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        wr(4'd2, 8'((p << 3) | (c << 1)));
        wr(4'd3, 8'h00);
        n = 0;
        while (!conv_start && n < 2000) begin @(negedge clk); n++; end
        chk(n == (p + 1) * (2 << c), "R2 latency", n, (p + 1) * (2 << c));
        @(negedge clk);
        chk(conv_start == 1'b0, "R2 pulse width", int'(conv_start), 0);
        stop_pulse();
      end
    end

    // single-shot, length 4, fixed channel 5, full resolution
    core_en = 1'b1;
    wr(4'd2, 8'h00);
    s = log_n;
    wr(4'd3, 8'h14);
    wait_seq();
    chk(log_n - s == 4, "R3 count4", log_n - s, 4);
    for (int k = 0; k < 4; k++)
      chk(log_chan[(s + k) & 255] == 3'd5, "R6 channel", log_chan[(s + k) & 255], 5);
    rd(4'd4, d); chk(d == 16'h10F, "R3 status", d, 16'h10F);
    rd(4'd10, d); chk(d == 16'(log_samp[(s + 2) & 255]), "R8 full", d, log_samp[(s + 2) & 255]);
    rd(4'd4, d); chk(d == 16'h10B, "R5 read clear", d, 16'h10B);
    for (int k = 0; k < 4; k++) begin
      if (k != 2) begin
        rd(4'(8 + k), d);
        chk(d == 16'(log_samp[(s + k) & 255]), "R8 full", d, log_samp[(s + k) & 255]);
      end
    end
    rd(4'd4, d); chk(d == 16'h100, "R5 all cleared", d, 16'h100);
    quiet(200, s + 4, "R3 stays idle");

    // length 8, channel stepping from 6, 8-bit results
    wr(4'd1, 8'h01); wr(4'd2, 8'h01);
    s = log_n;
    wr(4'd3, 8'h1A);
    wait_seq();
    chk(log_n - s == 8, "R3 count8", log_n - s, 8);
    rd(4'd4, d); chk(d == 16'h1FF, "R3 status8", d, 16'h1FF);
    for (int k = 0; k < 8; k++) begin
      chk(log_chan[(s + k) & 255] == 3'((6 + k) % 8), "R7 step8", log_chan[(s + k) & 255], (6 + k) % 8);
      rd(4'(8 + k), d);
      chk(d == 16'(log_samp[(s + k) & 255] >> 2), "R8 shifted", d, log_samp[(s + k) & 255] >> 2);
    end

    // length 4, channel stepping from 6, wraps inside 4..7
    wr(4'd1, 8'h00); wr(4'd2, 8'h00);
    s = log_n;
    wr(4'd3, 8'h1A);
    wait_seq();
    for (int k = 0; k < 4; k++)
      chk(log_chan[(s + k) & 255] == 3'(4 + ((6 + k) % 4)), "R7 step4",
          log_chan[(s + k) & 255], 4 + ((6 + k) % 4));

    // scan mode, length 4, channel 1
    s = log_n;
    wr(4'd3, 8'h05);
    while (log_n < s + 6) @(negedge clk);
    @(negedge clk); stop_in = 1'b1;
    @(negedge clk); stop_in = 1'b0;
    repeat (10) @(negedge clk);
    chk(log_n == s + 6, "R4 scan loops", log_n - s, 6);
    rd(4'd4, d); chk(d == 16'h10F, "R4 status", d, 16'h10F);
    rd(4'd8, d); chk(d == 16'(log_samp[(s + 4) & 255]), "R4 slot0 rewritten", d, log_samp[(s + 4) & 255]);
    rd(4'd9, d); chk(d == 16'(log_samp[(s + 1) & 255]), "R9 late done dropped", d, log_samp[(s + 1) & 255]);

    // R12 restart during a slow sequence
    wr(4'd2, 8'h3E);
    s = log_n;
    wr(4'd3, 8'h00);
    while (log_n < s + 2) @(negedge clk);
    repeat (5) @(negedge clk);
    wr(4'd3, 8'h00);
    s = log_n;
    rd(4'd4, d); chk(d == 16'h0, "R12 flags cleared", d, 0);
    wait_seq();
    chk(log_n - s == 4, "R12 count", log_n - s, 4);
    rd(4'd8, d); chk(d == 16'(log_samp[s & 255]), "R12 slot0", d, log_samp[s & 255]);

    // R9 stop during conversion and during sampling
    wr(4'd2, 8'h00);
    s = log_n;
    wr(4'd3, 8'h00);
    while (log_n < s + 1) @(negedge clk);
    stop_pulse();
    repeat (10) @(negedge clk);
    rd(4'd4, d); chk(d == 16'h0, "R9 no store", d, 0);
    quiet(300, s + 1, "R9 no restart");
    wr(4'd2, 8'h3E);
    s = log_n;
    wr(4'd3, 8'h00);
    repeat (50) @(negedge clk);
    stop_pulse();
    quiet(400, s, "R9 sample abort");

    // R10 wait with and without halt enable
    wr(4'd2, 8'h00); wr(4'd0, 8'h03);
    wait_in = 1'b1;
    s = log_n;
    wr(4'd3, 8'h00);
    quiet(200, s, "R10 halted");
    wait_in = 1'b0;
    wait_seq();
    chk(log_n - s == 4, "R10 resumed", log_n - s, 4);
    wr(4'd0, 8'h01);
    wait_in = 1'b1;
    s = log_n;
    wr(4'd3, 8'h00);
    wait_seq();
    chk(log_n - s == 4, "R10 ignored", log_n - s, 4);
    wait_in = 1'b0;

    // R11 power-down
    wr(4'd0, 8'h00);
    s = log_n;
    wr(4'd3, 8'h14);
    quiet(200, s, "R11 halted");
    rd(4'd3, d); chk(d == 16'h14, "R11 readable", d, 16'h14);
    rd(4'd4, d); chk(d == 16'h0, "R11 status", d, 0);
    wr(4'd0, 8'h01);
    wait_seq();
    chk(log_n - s == 4, "R11 resumed", log_n - s, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule